// File: doc/BRIEF.md
# Strobed Handshake Input Port

This block is a parameterized input port that takes bytes from an external sender over a two-wire handshake. The sender places a byte on the data pins and pulls an active-low strobe line low. The port synchronizes the strobe to its own clock and finds the falling edge. On that edge it captures the pins into a holding register and raises a buffer-full flag. The host sees the flag, takes the byte, and pulses a read strobe. The read lowers the flag, and the sender can then offer the next byte.

An interrupt request output reports new bytes. It is gated by an enable level that comes from a control register outside this block. The request is raised only by a strobe edge that arrives while the enable is high. Dropping the enable clears the request at once. Raising the enable again does not bring the request back, and the next strobe edge is needed for that. The request can drive an interrupt controller, or the host can poll it. A mode-entry pulse returns the handshake to its idle state but keeps the last captured byte.

Top module: `hs_in_port`

## Requirements
- R1: A falling edge on `stb_n` loads `pin_data` into `rd_data` and sets `buf_full`. With `SYNC_STAGES`=2, both outputs change on the third rising clock edge after `stb_n` goes low.
- R2: A one-cycle pulse on `rd_strobe` with no capture in the same cycle clears `buf_full` on the next clock edge. `rd_data` keeps the byte.
- R3: `irq` rises only in the cycle after a detected strobe falling edge, and only while `irq_en` is high. After such an edge, `irq` is 1 whenever `irq_en` was 1.
- R4: A clock edge at which `irq_en` is low leaves `irq` at 0.
- R5: Raising `irq_en` again after it was low never raises `irq` by itself, even while `buf_full` is 1. `irq` rises again only at the next strobe falling edge.
- R6: A one-cycle `mode_enter` pulse clears `buf_full` and `irq` on the next clock edge, and this takes priority over a capture or a read.
- R7: `mode_enter` does not clear `rd_data`.
- R8: A `rd_strobe` pulse clears `irq` on the next clock edge.
- R9: A strobe falling edge that arrives while `buf_full` is 1 overwrites `rd_data`, and `buf_full` stays 1.
- R10: A rising edge on `stb_n` changes none of `rd_data`, `buf_full` or `irq`.
- R11: Reset (`rst_n` low) sets `rd_data` to 0, `buf_full` to 0 and `irq` to 0.
- R12: When a read and a capture fall in the same clock cycle, the capture wins. `buf_full` ends at 1, `rd_data` takes the new byte, and `irq` is set if `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_n | input | 1 | Active-low strobe from the sender, asynchronous |
| pin_data | input | DATA_W | Data pins from the sender |
| rd_strobe | input | 1 | One-cycle pulse when the host reads the byte |
| irq_en | input | 1 | Interrupt enable level from the control register |
| mode_enter | input | 1 | One-cycle pulse on entry into handshake mode |
| rd_data | output | DATA_W | Last captured byte |
| buf_full | output | 1 | A captured byte is waiting |
| irq | output | 1 | Interrupt request for a new byte |

## Verification
The assertions assume the sender behaves. Each strobe level is held for at least `SYNC_STAGES`+1 clock cycles. The data pins stay stable from the strobe's falling edge until the capture. `rd_strobe` and `mode_enter` are single-cycle pulses. The bench drives the strobe low and holds it, with the pins fixed, for three cycles before it releases it. It then waits three more cycles before the next byte and changes the pins only together with a new falling edge. Reads and mode entry are issued one cycle at a time. The one deliberate overlap is a read placed in the same cycle as a capture, which tests the priority in R12.

// File: rtl/hs_in_pkg.sv
package hs_in_pkg;

   // Events seen by a handshake flag in one clock cycle.
   typedef struct packed {
      logic entry;    // return to idle on mode entry
      logic capture;  // strobe falling edge detected
      logic read;     // host consumed the byte
   } hs_evt_t;

   // Priority: mode entry clears, capture sets, read clears, else hold.
   function automatic logic hs_flag_next(input hs_evt_t ev, input logic cur);
      logic nxt;
      if (ev.entry)
         nxt = 1'b0;
      else if (ev.capture)
         nxt = 1'b1;
      else if (ev.read)
         nxt = 1'b0;
      else
         nxt = cur;
      return nxt;
   endfunction

endpackage

// File: rtl/hs_strobe_sync.sv
module hs_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_n,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;
   logic          prev;

   initial begin
      if (STAGES < 2) $fatal(1, "hs_strobe_sync: STAGES must be at least 2");
   end

   // Idle level of the strobe is high, so every stage resets high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain[0] <= 1'b1;
      else
         chain[0] <= stb_n;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= 1'b1;
         else
            chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev <= 1'b1;
      else
         prev <= chain[LAST];
   end

   assign fall = prev & ~chain[LAST];

endmodule

// File: rtl/hs_data_latch.sv
module hs_data_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (WIDTH < 1) $fatal(1, "hs_data_latch: WIDTH must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/hs_req_flag.sv
module hs_req_flag
   import hs_in_pkg::*;
#(
   parameter bit GATED = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  hs_evt_t ev,
   input  logic    gate,
   output logic    q
);
   logic nxt;

   if (GATED) begin : g_gated
      // A low gate forces the flag low. Only a fresh capture can set it again.
      always_comb nxt = gate ? hs_flag_next(ev, q) : 1'b0;
   end else begin : g_plain
      logic unused_gate;
      assign unused_gate = gate;
      always_comb nxt = hs_flag_next(ev, q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else
         q <= nxt;
   end

endmodule

// File: rtl/hs_in_port.sv
module hs_in_port
   import hs_in_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_n,
   input  logic [DATA_W-1:0] pin_data,
   input  logic              rd_strobe,
   input  logic              irq_en,
   input  logic              mode_enter,
   output logic [DATA_W-1:0] rd_data,
   output logic              buf_full,
   output logic              irq
);
   logic    strobe_fall;
   hs_evt_t ev;

   hs_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .stb_n (stb_n),
      .fall  (strobe_fall)
   );

   // The pins are sampled in the cycle the edge is detected. Mode entry keeps the byte.
   hs_data_latch #(.WIDTH(DATA_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (strobe_fall),
      .d     (pin_data),
      .q     (rd_data)
   );

   always_comb begin
      ev.entry   = mode_enter;
      ev.capture = strobe_fall;
      ev.read    = rd_strobe;
   end

   hs_req_flag #(.GATED(1'b0)) u_full (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .gate  (1'b1),
      .q     (buf_full)
   );

   hs_req_flag #(.GATED(1'b1)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .gate  (irq_en),
      .q     (irq)
   );

endmodule

// File: rtl/hs_in_port_chk.sv
module hs_in_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strobe_fall,
   input logic [DATA_W-1:0] pin_data,
   input logic              rd_strobe,
   input logic              irq_en,
   input logic              mode_enter,
   input logic [DATA_W-1:0] rd_data,
   input logic              buf_full,
   input logic              irq
);
   AST_CAPTURE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n) (strobe_fall && !mode_enter) |=> buf_full); // R1
   AST_CAPTURE_DATA: assert property (@(posedge clk) disable iff (!rst_n) strobe_fall |=> (rd_data == $past(pin_data))); // R1
   AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n) (rd_strobe && !strobe_fall) |=> !buf_full); // R2
   AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> buf_full); // R3
   AST_IRQ_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n) !irq_en |=> !irq); // R4
   AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(strobe_fall)); // R5
   AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) mode_enter |=> (!buf_full && !irq)); // R6
   AST_ENTRY_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (mode_enter && !strobe_fall) |=> $stable(rd_data)); // R7
   AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (rd_strobe && !strobe_fall) |=> !irq); // R8
   AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (strobe_fall && rd_strobe && irq_en && !mode_enter) |=> (buf_full && irq)); // R12
endmodule

bind hs_in_port hs_in_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .strobe_fall (strobe_fall),
   .pin_data    (pin_data),
   .rd_strobe   (rd_strobe),
   .irq_en      (irq_en),
   .mode_enter  (mode_enter),
   .rd_data     (rd_data),
   .buf_full    (buf_full),
   .irq         (irq)
);

// File: tb/hs_in_port_test.sv
module hs_in_port_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         stb_n = 1'b1;
   logic [W-1:0] pin_data = '0;
   logic         rd_strobe = 1'b0;
   logic         irq_en = 1'b0;
   logic         mode_enter = 1'b0;
   logic [W-1:0] rd_data;
   logic         buf_full;
   logic         irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   hs_in_port #(.DATA_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .pin_data(pin_data),
      .rd_strobe(rd_strobe), .irq_en(irq_en), .mode_enter(mode_enter),
      .rd_data(rd_data), .buf_full(buf_full), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Strobe falls with byte d. The capture is visible three negedges later.
   // With rd_mid set, a read pulse is placed in the capture cycle.
   task automatic drop(input logic [W-1:0] d, input bit rd_mid);
      @(negedge clk);
      pin_data = d;
      stb_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      if (rd_mid) rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic lift();
      @(negedge clk);
      stb_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic host_read();
      @(negedge clk);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic set_en(input logic v);
      @(negedge clk);
      irq_en = v;
      @(negedge clk);
   endtask

   task automatic enter();
      @(negedge clk);
      mode_enter = 1'b1;
      @(negedge clk);
      mode_enter = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 rd_data", rd_data, 0);
      check("R11 buf_full", buf_full, 0);
      check("R11 irq", irq, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Sweep every byte, with the enable level following the low bit.
      for (int v = 0; v < 256; v++) begin
         set_en(v[0]);
         drop(v[W-1:0], 1'b0);
         check("R1 data", rd_data, v);
         check("R1 full", buf_full, 1);
         check(v[0] ? "R3 irq on edge" : "R4 irq gated", irq, v[0]);
         lift();
         check("R10 data after rise", rd_data, v);
         check("R10 full after rise", buf_full, 1);
         check("R10 irq after rise", irq, v[0]);
         host_read();
         check("R2 full cleared", buf_full, 0);
         check("R2 data held", rd_data, v);
         check("R8 irq cleared", irq, 0);
      end

      // Overwrite while full
      set_en(1'b0);
      drop(8'h11, 1'b0);
      lift();
      drop(8'h22, 1'b0);
      check("R9 data overwritten", rd_data, 32'h22);
      check("R9 full stays", buf_full, 1);
      lift();
      host_read();

      // Enable toggling does not create a request
      set_en(1'b1);
      drop(8'h33, 1'b0);
      check("R3 irq set", irq, 1);
      set_en(1'b0);
      check("R4 irq forced low", irq, 0);
      set_en(1'b1);
      check("R5 no irq on re-enable", irq, 0);
      check("R5 full still set", buf_full, 1);
      lift();
      check("R5 no irq on rise", irq, 0);
      host_read();
      drop(8'h44, 1'b0);
      check("R5 irq on next edge", irq, 1);
      lift();
      host_read();

      // Read collides with capture
      drop(8'h55, 1'b1);
      check("R12 full", buf_full, 1);
      check("R12 data", rd_data, 32'h55);
      check("R12 irq", irq, 1);
      lift();
      host_read();

      // Mode entry
      drop(8'h66, 1'b0);
      lift();
      enter();
      check("R6 full cleared", buf_full, 0);
      check("R6 irq cleared", irq, 0);
      check("R7 data kept", rd_data, 32'h66);
      set_en(1'b0);

      summary();
   end

endmodule